// File: doc/BRIEF.md
# Mode-banked register file controller

This block is the architectural register file of a small processor core together with the logic that tracks which execution mode the core is in. It offers two combinational read ports and one synchronous write port, all addressed by a register number from 0 to 15. The stack pointer (13) and link register (14) are resolved to a private physical copy that depends on the current mode. Every other register number reaches one shared physical register.

A status register holds the mode in its five low bits and free-form flags in the upper bits. Software running at the privileged level may rewrite it. A rewrite that would enter an unknown encoding, or leave user mode, or go straight from system mode to user mode, is dropped and raises a one-cycle error flag. An exception-entry request names one of five exception kinds. In a single cycle it copies the live status into the target mode's saved status register, stores the supplied return address in that mode's link register, and switches the mode.

The mode register is the state machine. Its states are USR, FIQ, IRQ, SVC, ABT, UND and SYS. Three kinds of transition exist. A legal status write goes from any privileged state to any known state, except SYS to USR. An exception entry goes from any state to FIQ, IRQ, SVC, ABT or UND. A hold keeps the state when there is no request or when the request is refused. Reset enters SVC.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset the mode is supervisor (10011), the status register reads 0x00000013, the privilege output is 1, the error flag is 0, the saved status output is 0, and all registers read 0.
- R2: The privilege output is 0 in user mode (10000) and 1 in every other mode.
- R3: Register numbers 0 to 12 and 15 select one shared physical register each: a value written in one mode reads back unchanged in every other mode.
- R4: User mode and system mode (11111) share one sp (13) and one lr (14), and the saved status output reads 0 in both.
- R5: FIQ (10001), IRQ (10010), supervisor (10011), abort (10111) and undefined (11011) each own a private sp, lr and saved status register, and each keeps its contents while other modes run.
- R6: A status write in a privileged mode whose bits [4:0] hold a known mode encoding takes effect at the next clock edge, loading the mode and the upper bits. It is not flagged.
- R7: A status write while in user mode leaves the whole status register unchanged and raises the error flag for the cycle after the write edge.
- R8: A status write from system mode to user mode is refused and flagged like R7.
- R9: A status write whose bits [4:0] are not one of the seven known encodings is refused and flagged like R7.
- R10: An exception request with kind 0 (FIQ), 1 (IRQ), 2 (supervisor), 3 (abort) or 4 (undefined) copies the current status into the target's saved status, writes the return address into the target's lr and enters the target mode, all at one clock edge. Kinds 5 to 7 have no effect.
- R11: A valid exception request wins over a status write in the same cycle; that write is dropped without a flag. The exception's lr write also wins over a register write to the same physical lr.
- R12: Both read ports are combinational. A register write becomes visible at the clock edge, so a read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | DATA_W | Register write data |
| psr_wr_en | input | 1 | Status register write request |
| psr_wr_data | input | DATA_W | New status value, mode in bits [4:0] |
| exc_en | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception kind, 0 to 4 valid |
| exc_ret_addr | input | DATA_W | Return address stored in the target lr |
| psr_out | output | DATA_W | Current status register |
| spsr_out | output | DATA_W | Saved status of the current mode, 0 in user or system |
| mode_out | output | 5 | Current mode encoding |
| priv_out | output | 1 | Privilege level, 1 when privileged |
| illegal_mode_out | output | 1 | One-cycle flag for a refused status write |

## Verification
A table of steps moves the core through every mode by status writes and by exceptions. It writes sp and lr in each mode and reads them back after later switches, which separates real per-mode banking from a single shared copy. It also separates banking from the user/system aliasing of R4. The refused writes (from user, system to user, unknown encoding) sit between legal ones. Each is checked for an unchanged mode and for the flag, which separates a refused write from a silently accepted one. Directed steps follow. They cover the reset state, saved-status contents after chained exceptions, and an invalid exception kind. They also cover an exception colliding with a status write and with an lr write in the same cycle, and a read of a register in the cycle it is written.

// File: rtl/mbrf_pkg.sv
`timescale 1ns/1ps
package mbrf_pkg;
    localparam int MODE_W    = 5;
    localparam int NUM_REGS  = 16;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int KIND_W    = 3;
    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(13);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(14);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mbrf_mode_fsm.sv
`timescale 1ns/1ps
module mbrf_mode_fsm
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psr_wr_en,
    input  logic [DATA_W-1:0]       psr_wr_data,
    input  logic                    exc_en,
    input  logic [KIND_W-1:0]       exc_kind,
    output mode_e                   mode_q,
    output logic [DATA_W-1:0]       psr,
    output logic                    priv,
    output logic [BANK_W-1:0]       cur_bank,
    output logic                    exc_take,
    output logic [BANK_W-1:0]       exc_bank,
    output logic                    illegal_q
);
    localparam int HI_W = DATA_W - MODE_W;

    mode_e             mode_d, exc_mode;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic              bad_d, exc_ok, write_ok;
    logic [MODE_W-1:0] req;

    // exception kind to target mode
    always_comb begin
        exc_ok   = 1'b1;
        exc_mode = MODE_SVC;
        unique case (exc_kind)
            3'd0:    exc_mode = MODE_FIQ;
            3'd1:    exc_mode = MODE_IRQ;
            3'd2:    exc_mode = MODE_SVC;
            3'd3:    exc_mode = MODE_ABT;
            3'd4:    exc_mode = MODE_UND;
            default: exc_ok   = 1'b0;
        endcase
    end

    // transition logic
    always_comb begin
        mode_d   = mode_q;
        hi_d     = hi_q;
        bad_d    = 1'b0;
        exc_take = 1'b0;
        req      = psr_wr_data[MODE_W-1:0];
        write_ok = mode_known(req);
        unique case (mode_q)
            MODE_USR: write_ok = 1'b0;
            MODE_SYS: if (req == MODE_USR) write_ok = 1'b0;
            default:  ;
        endcase
        if (exc_en && exc_ok) begin
            exc_take = 1'b1;
            mode_d   = exc_mode;
        end else if (psr_wr_en) begin
            if (write_ok) begin
                mode_d = mode_e'(req);
                hi_d   = psr_wr_data[DATA_W-1:MODE_W];
            end else begin
                bad_d  = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_SVC;
            hi_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            hi_q      <= hi_d;
            illegal_q <= bad_d;
        end
    end

    // outputs
    always_comb begin
        psr      = {hi_q, mode_q};
        priv     = (mode_q != MODE_USR);
        cur_bank = '0;
        unique case (mode_q)
            MODE_USR, MODE_SYS: cur_bank = BANK_W'(0);
            MODE_FIQ:           cur_bank = BANK_W'(1);
            MODE_IRQ:           cur_bank = BANK_W'(2);
            MODE_SVC:           cur_bank = BANK_W'(3);
            MODE_ABT:           cur_bank = BANK_W'(4);
            MODE_UND:           cur_bank = BANK_W'(5);
            default:            cur_bank = '0;
        endcase
        exc_bank = BANK_W'(exc_kind) + BANK_W'(1);
    end

    assert_user_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_USR && !exc_take) |=> (mode_q == MODE_USR));
    assert_no_sys_to_usr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SYS && !exc_take) |=> (mode_q != MODE_USR));
    assert_exc_privileged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (mode_q != MODE_USR && mode_q != MODE_SYS));
    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> ($past(psr_wr_en) && $stable(mode_q)));
endmodule

// File: rtl/mbrf_regs.sv
`timescale 1ns/1ps
module mbrf_regs
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exc_we,
    input  logic [BANK_W-1:0] exc_bank,
    input  logic [DATA_W-1:0] exc_ret,
    input  logic [DATA_W-1:0] exc_psr,
    output logic [DATA_W-1:0] gpr_q  [NUM_REGS],
    output logic [DATA_W-1:0] sp_q   [NUM_BANKS],
    output logic [DATA_W-1:0] lr_q   [NUM_BANKS],
    output logic [DATA_W-1:0] spsr_q [NUM_BANKS]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) gpr_q[i] <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                sp_q[b]   <= '0;
                lr_q[b]   <= '0;
                spsr_q[b] <= '0;
            end
        end else begin
            if (wr_en) begin
                if (wr_idx == SP_IDX)      sp_q[cur_bank] <= wr_data;
                else if (wr_idx == LR_IDX) lr_q[cur_bank] <= wr_data;
                else                       gpr_q[wr_idx]  <= wr_data;
            end
            // later assignment: exception lr write wins
            if (exc_we) begin
                lr_q[exc_bank]   <= exc_ret;
                spsr_q[exc_bank] <= exc_psr;
            end
        end
    end

    assert_exc_lr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_we |=> (lr_q[$past(exc_bank)] == $past(exc_ret)));
    assert_exc_spsr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_we |=> (spsr_q[$past(exc_bank)] == $past(exc_psr)));
endmodule

// File: rtl/mbrf_read_port.sv
`timescale 1ns/1ps
module mbrf_read_port
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [BANK_W-1:0] bank,
    input  logic [DATA_W-1:0] gpr_q [NUM_REGS],
    input  logic [DATA_W-1:0] sp_q  [NUM_BANKS],
    input  logic [DATA_W-1:0] lr_q  [NUM_BANKS],
    output logic [DATA_W-1:0] data
);
    always_comb begin
        if (idx == SP_IDX)      data = sp_q[bank];
        else if (idx == LR_IDX) data = lr_q[bank];
        else                    data = gpr_q[idx];
    end
endmodule

// File: rtl/mode_bank_regfile.sv
`timescale 1ns/1ps
module mode_bank_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              psr_wr_en,
    input  logic [DATA_W-1:0] psr_wr_data,
    input  logic              exc_en,
    input  logic [2:0]        exc_kind,
    input  logic [DATA_W-1:0] exc_ret_addr,
    output logic [DATA_W-1:0] psr_out,
    output logic [DATA_W-1:0] spsr_out,
    output logic [4:0]        mode_out,
    output logic              priv_out,
    output logic              illegal_mode_out
);
    localparam int NUM_RD = 2;

    mode_e             mode_q;
    logic [BANK_W-1:0] cur_bank, exc_bank;
    logic              exc_take;
    logic [DATA_W-1:0] gpr_q  [NUM_REGS];
    logic [DATA_W-1:0] sp_q   [NUM_BANKS];
    logic [DATA_W-1:0] lr_q   [NUM_BANKS];
    logic [DATA_W-1:0] spsr_q [NUM_BANKS];
    logic [IDX_W-1:0]  rd_idx  [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];

    mbrf_mode_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .exc_en(exc_en), .exc_kind(exc_kind),
        .mode_q(mode_q), .psr(psr_out), .priv(priv_out),
        .cur_bank(cur_bank), .exc_take(exc_take), .exc_bank(exc_bank),
        .illegal_q(illegal_mode_out)
    );

    mbrf_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cur_bank(cur_bank),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exc_we(exc_take), .exc_bank(exc_bank),
        .exc_ret(exc_ret_addr), .exc_psr(psr_out),
        .gpr_q(gpr_q), .sp_q(sp_q), .lr_q(lr_q), .spsr_q(spsr_q)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mbrf_read_port #(.DATA_W(DATA_W)) u_port (
            .idx(rd_idx[p]), .bank(cur_bank),
            .gpr_q(gpr_q), .sp_q(sp_q), .lr_q(lr_q),
            .data(rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign mode_out  = mode_q;
    assign spsr_out  = (cur_bank == '0) ? '0 : spsr_q[cur_bank];

    assert_priv_follows_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        priv_out |-> (mode_out != 5'b10000));
endmodule

// File: tb/test_mode_bank_regfile.sv
`timescale 1ns/1ps
module test_mode_bank_regfile;
    localparam int VW = 80;
    localparam int NVEC = 23;
    // op 0 reg write, 1 status write, 2 exception, 3 none
    // {op[2], arg[4], data[32], rd_idx[4], exp_rd[32], exp_mode[5], exp_flag}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  32'h11110000, 4'd0,  32'h11110000, 5'h13, 1'b0}, // R3 R12
        {2'd0, 4'd13, 32'h5C000000, 4'd13, 32'h5C000000, 5'h13, 1'b0},
        {2'd0, 4'd14, 32'h5C0000EE, 4'd14, 32'h5C0000EE, 5'h13, 1'b0},
        {2'd1, 4'd0,  32'h0000001F, 4'd13, 32'h00000000, 5'h1F, 1'b0}, // R6
        {2'd0, 4'd13, 32'hAAAA0013, 4'd13, 32'hAAAA0013, 5'h1F, 1'b0},
        {2'd1, 4'd0,  32'h00000010, 4'd13, 32'hAAAA0013, 5'h1F, 1'b1}, // R8
        {2'd1, 4'd0,  32'h00000012, 4'd0,  32'h11110000, 5'h12, 1'b0}, // R3
        {2'd0, 4'd13, 32'h12120013, 4'd13, 32'h12120013, 5'h12, 1'b0},
        {2'd1, 4'd0,  32'h00000015, 4'd13, 32'h12120013, 5'h12, 1'b1}, // R9
        {2'd1, 4'd0,  32'hF0000010, 4'd13, 32'hAAAA0013, 5'h10, 1'b0}, // R4
        {2'd1, 4'd0,  32'h00000013, 4'd13, 32'hAAAA0013, 5'h10, 1'b1}, // R7
        {2'd0, 4'd14, 32'h0B0B0014, 4'd14, 32'h0B0B0014, 5'h10, 1'b0},
        {2'd2, 4'd1,  32'h00008004, 4'd14, 32'h00008004, 5'h12, 1'b0}, // R10
        {2'd3, 4'd0,  32'h00000000, 4'd13, 32'h12120013, 5'h12, 1'b0}, // R5
        {2'd2, 4'd0,  32'h00000100, 4'd14, 32'h00000100, 5'h11, 1'b0},
        {2'd0, 4'd13, 32'hF1F10000, 4'd13, 32'hF1F10000, 5'h11, 1'b0},
        {2'd1, 4'd0,  32'h00000013, 4'd13, 32'h5C000000, 5'h13, 1'b0}, // R5
        {2'd3, 4'd0,  32'h00000000, 4'd14, 32'h5C0000EE, 5'h13, 1'b0},
        {2'd2, 4'd5,  32'h00000999, 4'd14, 32'h5C0000EE, 5'h13, 1'b0}, // R10 bad kind
        {2'd2, 4'd3,  32'hABCD0000, 4'd14, 32'hABCD0000, 5'h17, 1'b0},
        {2'd1, 4'd0,  32'h0000001F, 4'd14, 32'h0B0B0014, 5'h1F, 1'b0}, // R4
        {2'd2, 4'd4,  32'h00000044, 4'd14, 32'h00000044, 5'h1B, 1'b0},
        {2'd3, 4'd0,  32'h00000000, 4'd0,  32'h11110000, 5'h1B, 1'b0}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wr_data = '0, exc_ret_addr = '0;
    logic        wr_en = 1'b0, psr_wr_en = 1'b0, exc_en = 1'b0;
    logic [2:0]  exc_kind = '0;
    logic [31:0] psr_out, spsr_out;
    logic [4:0]  mode_out;
    logic        priv_out, illegal_mode_out;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    mode_bank_regfile i_mode_bank_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .exc_en(exc_en), .exc_kind(exc_kind), .exc_ret_addr(exc_ret_addr),
        .psr_out(psr_out), .spsr_out(spsr_out), .mode_out(mode_out),
        .priv_out(priv_out), .illegal_mode_out(illegal_mode_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at negedge, release after the edge, sample 1 ns after it
    task automatic step(input logic [1:0] op, input logic [3:0] arg, input logic [31:0] d,
                        input logic [3:0] rdi);
        @(negedge clk);
        wr_en = (op == 2'd0); psr_wr_en = (op == 2'd1); exc_en = (op == 2'd2);
        wr_idx = arg; exc_kind = arg[2:0];
        wr_data = d; psr_wr_data = d; exc_ret_addr = d;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0; psr_wr_en = 1'b0; exc_en = 1'b0;
        rd_a_idx = rdi;
        #0.5;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 mode", {27'd0, mode_out}, 32'h13);
        check("R1 psr", psr_out, 32'h13);
        check("R1 priv", {31'd0, priv_out}, 32'd1);
        check("R1 flag", {31'd0, illegal_mode_out}, 32'd0);
        check("R1 spsr", spsr_out, 32'd0);
        check("R1 reg", rd_a_data, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            step(v[79:78], v[77:74], v[73:42], v[41:38]);
            check($sformatf("R3-vector %0d rd", k), rd_a_data, v[37:6]);
            check($sformatf("R6 vector %0d mode", k), {27'd0, mode_out}, {27'd0, v[5:1]});
            check($sformatf("R9 vector %0d flag", k), {31'd0, illegal_mode_out}, {31'd0, v[0]});
        end

        // R10 saved status after chained exceptions: und entered from sys (0x1F)
        check("R10 psr und", psr_out, 32'h1B);
        check("R10 spsr und", spsr_out, 32'h1F);
        check("R2 priv und", {31'd0, priv_out}, 32'd1);

        // R2 R4: go to user
        step(2'd1, 4'd0, 32'h00000010, 4'd14);
        check("R2 priv user", {31'd0, priv_out}, 32'd0);
        check("R4 spsr user", spsr_out, 32'd0);

        // R11: exception + status write same cycle from user
        @(negedge clk);
        exc_en = 1'b1; exc_kind = 3'd2; exc_ret_addr = 32'h00001111;
        psr_wr_en = 1'b1; psr_wr_data = 32'h0000001F;
        @(posedge clk); #0.5;
        exc_en = 1'b0; psr_wr_en = 1'b0; rd_a_idx = 4'd14; #0.5;
        check("R11 mode", {27'd0, mode_out}, 32'h13);
        check("R11 flag", {31'd0, illegal_mode_out}, 32'd0);
        check("R11 spsr", spsr_out, 32'h10);
        check("R11 lr", rd_a_data, 32'h00001111);

        // R11: exception into current mode collides with lr write
        @(negedge clk);
        exc_en = 1'b1; exc_kind = 3'd2; exc_ret_addr = 32'h00002222;
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h0000DEAD;
        @(posedge clk); #0.5;
        exc_en = 1'b0; wr_en = 1'b0; #0.5;
        check("R11 lr collide", rd_a_data, 32'h00002222);
        check("R11 spsr svc", spsr_out, 32'h13);

        // R12 port B and same-cycle read
        rd_b_idx = 4'd13; #0.5;
        check("R12 port b sp", rd_b_data, 32'h5C000000);
        rd_b_idx = 4'd0; #0.5;
        check("R12 port b r0", rd_b_data, 32'h11110000);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h00000077; rd_a_idx = 4'd1;
        #0.5;
        check("R12 old value", rd_a_data, 32'd0);
        @(posedge clk); #0.5;
        wr_en = 1'b0; #0.5;
        check("R12 new value", rd_a_data, 32'h00000077);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule